// File: doc/BRIEF.md
# Clocked Serial Port with Status Flags

This block is a byte-wide synchronous serial port. It has one data output, one data input and a serial clock. In internal mode the block drives the serial clock from a programmable divider. In external mode a remote master supplies the clock. A small register port loads transmit bytes, collects received bytes, selects the mode and reads the status flags. Two level interrupt lines report "transmit buffer free" and "transmission finished".

A transmit byte first waits in a one-byte buffer. It moves into the shifter as soon as the shifter is idle and transmit is enabled. If software refills the buffer before the current frame ends, the next frame follows with no idle bit period. In internal mode the receiver is clocked by the clock the transmitter produces, so reception advances only while a frame is being sent. In external mode the two directions run independently.

Top module: `sync_serial_port`

## Requirements
- R1: After reset: status reads 0x01, control reads 0x00, `sclk_out` is 1, `sdo` is 0 and both interrupt lines are 0.
- R2: Register map (`addr`):
  - 0 is control: bit0 tx enable, bit1 rx enable, bit2 external clock, bit3 buffer-free interrupt enable, bit4 finished interrupt enable.
  - 1 is status: bit0 buffer empty, bit1 finished, bit2 rx full, bit3 overrun. Writing 1 to bit1 or to bit3 clears that flag.
  - 2 writes the transmit buffer and reads the receive byte.
  - 3 is the divider N.
- R3: Frames are 8 bits, least significant bit first. `sdo` changes on the falling serial clock edge and `sdi` is sampled on the rising edge. The internal clock rests at 1 when idle.
- R4: In internal mode one serial clock period is 2×(N+1) system clocks.
- R5: A write to address 2 clears the buffer-empty flag. The flag sets again in the cycle after the byte moves into an idle shifter. `irq_tx` = buffer-empty AND bit3 of control.
- R6: If the buffer is refilled before a frame ends and tx enable stays 1, the next frame starts on the very next falling edge. There is no gap, so falling edges stay one period apart.
- R7: The finished flag sets at the falling-edge slot that follows the last bit. In internal mode this is N+1 system clocks after the 8th rising edge. The flag clears by write-1 or when the next frame loads. `irq_done` = finished AND bit4 of control AND NOT bit3 of control.
- R8: In external mode the loaded frame's D0 appears after the first falling edge of `sclk_in` after loading. The finished flag sets after the 9th falling edge, which closes D7. `sclk_in` passes through two synchroniser stages.
- R9: In external mode the receiver shifts on `sclk_in` rising edges whether or not a transmission is running.
- R10: In internal mode `sclk_in` is ignored. The receiver only advances on the internal clock, which runs only while transmitting.
- R11: Rx full sets after the 8th sampled bit and clears when address 2 is read. If a frame completes while full is set, overrun sets and the receive byte holds the newest frame.
- R12: While tx enable is 0, a byte written to the buffer stays there and no serial clock is produced. It is sent once tx enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| sclk_in | input | 1 | External serial clock |
| sclk_out | output | 1 | Internally generated serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| irq_tx | output | 1 | Transmit buffer free interrupt |
| irq_done | output | 1 | Transmission finished interrupt |

## Verification
The hardest state to reach is the refill window. A second byte must land in the buffer after the first has moved to the shifter but before the last falling slot of the frame. The bench reaches it by waiting for `irq_tx` to rise right after the first load, writing the next byte at once, and measuring every gap between falling edges. Overrun and the newest-byte rule come from the same back-to-back pair, looped back and left unread. External-mode timing is driven edge by edge from the bench, which also checks the finished flag just before and just after the closing 9th edge.

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic         sclk_in,
  output logic         sclk_out,
  input  logic         sdi,
  output logic         sdo,
  output logic         irq_tx,
  output logic         irq_done
);
  localparam int CW = $clog2(W + 1);
  localparam int RW = $clog2(W);

  logic [4:0]    ctrl;
  logic [W-1:0]  tbuf, sh, rsh, rbuf, div, cnt;
  logic          empty, done, full, ovr, busy, sclk_int, sdo_r;
  logic [CW-1:0] txcnt;
  logic [RW-1:0] rcnt;
  logic [2:0]    sync;

  wire tx_en  = ctrl[0];
  wire rx_en  = ctrl[1];
  wire ext    = ctrl[2];
  wire wr_dat = wr_en && addr == 2'd2;
  wire wr_st  = wr_en && addr == 2'd1;
  wire rd_dat = rd_en && addr == 2'd2;

  wire expire    = busy && !ext && cnt == div;
  wire ext_fall  = ext && sync[2] && !sync[1];
  wire ext_rise  = ext && !sync[2] && sync[1];
  wire tick_fall = (expire && sclk_int) || ext_fall;
  wire tick_rise = (expire && !sclk_int) || ext_rise;
  wire last      = txcnt == CW'(W);
  wire reload    = !empty && tx_en;
  wire rx_last   = tick_rise && rx_en && rcnt == RW'(W - 1);
  wire [W-1:0] rsh_nx = {sdi, rsh[W-1:1]};

  assign sclk_out = ext ? 1'b1 : sclk_int;
  assign sdo      = sdo_r;
  assign irq_tx   = empty && ctrl[3];
  assign irq_done = done && ctrl[4] && !ctrl[3];

  always_comb begin
    case (addr)
      2'd0:    rdata = W'(ctrl);
      2'd1:    rdata = W'({ovr, full, done, empty});
      2'd2:    rdata = rbuf;
      default: rdata = div;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 3'b111;
    else        sync <= {sync[1:0], sclk_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      div  <= '0;
    end else if (wr_en) begin
      if (addr == 2'd0) ctrl <= wdata[4:0];
      if (addr == 2'd3) div  <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!busy || cnt == div) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbuf <= '0; sh <= '0; txcnt <= '0;
      empty <= 1'b1; done <= 1'b0; busy <= 1'b0;
      sclk_int <= 1'b1; sdo_r <= 1'b0;
    end else begin
      if (wr_st && wdata[1]) done <= 1'b0;
      if (!busy && reload) begin
        busy <= 1'b1; sh <= tbuf; txcnt <= '0;
        empty <= 1'b1; done <= 1'b0; sclk_int <= 1'b1;
      end else if (busy && tick_fall) begin
        if (!last) begin
          sdo_r <= sh[0]; sh <= sh >> 1; txcnt <= txcnt + 1'b1;
          sclk_int <= ext ? 1'b1 : 1'b0;
        end else if (reload) begin
          sdo_r <= tbuf[0]; sh <= tbuf >> 1; txcnt <= CW'(1);
          empty <= 1'b1; sclk_int <= ext ? 1'b1 : 1'b0;
        end else begin
          busy <= 1'b0; done <= 1'b1; sclk_int <= 1'b1;
        end
      end else if (busy && tick_rise && !ext) begin
        sclk_int <= 1'b1;
      end
      if (wr_dat) begin
        tbuf <= wdata; empty <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsh <= '0; rbuf <= '0; rcnt <= '0; full <= 1'b0; ovr <= 1'b0;
    end else begin
      if (wr_st && wdata[3]) ovr <= 1'b0;
      if (rd_dat) full <= 1'b0;
      if (!rx_en) begin
        rcnt <= '0;
      end else if (tick_rise) begin
        if (rx_last) begin
          rbuf <= rsh_nx; full <= 1'b1; rcnt <= '0;
          if (full && !rd_dat) ovr <= 1'b1;
        end else begin
          rsh <= rsh_nx; rcnt <= rcnt + 1'b1;
        end
      end
    end
  end

  assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk_int);
  assert_bitcount_R3: assert property (@(posedge clk) disable iff (!rst_n)
    txcnt <= CW'(W));
  assert_write_clears_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dat |=> !empty);
  assert_done_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(tick_fall));
  assert_read_clears_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dat && !rx_last) |=> !full);
  assert_int_ignores_pin_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext && !busy) |=> $stable(rcnt));
endmodule

// File: tb/sync_serial_port_test.sv
module sync_serial_port_test;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, sclk_in = 1, drv_sdi = 0, loop = 1;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic sclk_out, sdo, irq_tx, irq_done, sdi;
  int total = 0, bad = 0, cyc = 0;

  assign sdi = loop ? sdo : drv_sdi;
  always #5 clk = ~clk;

  sync_serial_port uut (.clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata,
    .sclk_in, .sclk_out, .sdi, .sdo, .irq_tx, .irq_done);

  logic [7:0] cap [4];
  logic [7:0] mbits;
  int ncap, mcnt, maxgap, firstgap, lastfall, nfall;
  always @(posedge clk) cyc = cyc + 1;
  always @(posedge sclk_out) begin
    mbits = {sdo, mbits[7:1]};
    mcnt++;
    if (mcnt == 8) begin
      if (ncap < 4) cap[ncap] = mbits;
      ncap++; mcnt = 0;
    end
  end
  always @(negedge sclk_out) begin
    nfall++;
    if (lastfall >= 0) begin
      if (firstgap < 0) firstgap = cyc - lastfall;
      if (cyc - lastfall > maxgap) maxgap = cyc - lastfall;
    end
    lastfall = cyc;
  end

  task automatic mon_clear();
    ncap = 0; mcnt = 0; maxgap = 0; firstgap = -1; lastfall = -1; nfall = 0;
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic ext_frame(input logic [7:0] rxpat, input int fin, output logic [7:0] got);
    for (int i = 0; i < 8; i++) begin
      sclk_in = 0; drv_sdi = rxpat[i];
      repeat (6) @(negedge clk);
      got[i] = sdo;
      sclk_in = 1;
      repeat (6) @(negedge clk);
    end
    if (fin != 0) begin
      check("R8 finished before closing edge", irq_done, 0);
      sclk_in = 0;
      repeat (6) @(negedge clk);
      check("R8 finished after 9th fall", irq_done, 1);
    end
  endtask

  localparam logic [15:0] VEC [6] = '{16'h00A5, 16'h013C, 16'h0381, 16'h07FF, 16'h0200, 16'h056E};

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d, got;
    int n;
    mon_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    bus_rd(2'd1, d); check("R1 status", d, 8'h01);
    bus_rd(2'd0, d); check("R1 control", d, 8'h00);
    check("R1 sclk_out", sclk_out, 1);
    check("R1 sdo", sdo, 0);
    check("R1 irqs", {irq_tx, irq_done}, 0);

    bus_wr(2'd0, 8'h13);
    foreach (VEC[k]) begin
      mon_clear();
      bus_wr(2'd3, VEC[k][15:8]);
      bus_wr(2'd2, VEC[k][7:0]);
      while (!irq_done) @(negedge clk);
      check("R3 lsb-first frame", cap[0], VEC[k][7:0]);
      check("R4 bit period", firstgap, 2 * (VEC[k][15:8] + 1));
      check("R3 idle high", sclk_out, 1);
      bus_rd(2'd2, d); check("R11 loopback byte", d, VEC[k][7:0]);
      bus_wr(2'd1, 8'h02);
      check("R7 write-1 clears finished", irq_done, 0);
    end

    mon_clear();
    bus_wr(2'd3, 8'd3);
    bus_wr(2'd2, 8'h55);
    repeat (8) @(posedge sclk_out);
    n = 0;
    while (!irq_done) begin @(posedge clk); #1 n++; end
    check("R7 finish delay internal", n, 4);
    bus_rd(2'd2, d);
    bus_wr(2'd2, 8'h0F);
    repeat (3) @(negedge clk);
    check("R7 new load clears finished", irq_done, 0);
    while (!irq_done) @(negedge clk);
    bus_rd(2'd2, d);
    bus_wr(2'd1, 8'h02);

    mon_clear();
    bus_wr(2'd3, 8'd1);
    bus_wr(2'd0, 8'h0B);
    bus_wr(2'd2, 8'h11);
    check("R5 write clears empty", irq_tx, 0);
    @(negedge clk);
    check("R5 empty after load", irq_tx, 1);
    bus_wr(2'd2, 8'h22);
    while (ncap < 2) @(negedge clk);
    repeat (20) @(negedge clk);
    check("R6 first byte", cap[0], 8'h11);
    check("R6 second byte", cap[1], 8'h22);
    check("R6 no gap", maxgap, 4);
    bus_rd(2'd1, d); check("R11 full and overrun", d & 8'h0C, 8'h0C);
    bus_rd(2'd2, d); check("R11 newest byte kept", d, 8'h22);
    bus_rd(2'd1, d); check("R11 read clears full", d[2], 0);
    bus_wr(2'd1, 8'h08);
    bus_rd(2'd1, d); check("R2 overrun write-1 clear", d[3], 0);

    mon_clear();
    bus_wr(2'd1, 8'h02);
    bus_wr(2'd0, 8'h02);
    bus_wr(2'd2, 8'h5A);
    repeat (50) @(negedge clk);
    check("R12 no clock while disabled", nfall, 0);
    bus_rd(2'd1, d); check("R12 byte held", d[0], 0);
    bus_wr(2'd0, 8'h03);
    while (ncap < 1) @(negedge clk);
    repeat (10) @(negedge clk);
    check("R12 held byte sent", cap[0], 8'h5A);
    bus_rd(2'd2, d);

    for (int i = 0; i < 10; i++) begin
      sclk_in = ~sclk_in; repeat (6) @(negedge clk);
    end
    bus_rd(2'd1, d); check("R10 pin ignored internal", d[2], 0);

    loop = 0; sclk_in = 1;
    bus_wr(2'd0, 8'h17);
    bus_wr(2'd2, 8'h96);
    repeat (4) @(negedge clk);
    ext_frame(8'h3C, 1, got);
    check("R8 external tx byte", got, 8'h96);
    bus_rd(2'd2, d); check("R9 external rx byte", d, 8'h3C);
    bus_wr(2'd0, 8'h04);
    sclk_in = 1; repeat (6) @(negedge clk);
    bus_wr(2'd0, 8'h06);
    ext_frame(8'hC5, 0, got);
    repeat (6) @(negedge clk);
    bus_rd(2'd1, d); check("R9 rx with tx idle full", d[2], 1);
    bus_rd(2'd2, d); check("R9 rx with tx idle", d, 8'hC5);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule